// File: doc/BRIEF.md
# Multiplexer Frame and Accumulation Sequencer

This block sets the timing for a three-phase metering front end. It is driven by a slow tick that pulses once per period of a 32768 Hz reference. From that tick it steps through a fixed frame of 13 ticks. The frame has six sample slots of two ticks each, one for the current input and one for the voltage input of each phase. A single idle tick closes the frame. For every slot the block presents a channel number and a sample strobe to the converter.

Completed frames are counted at two levels. First they are grouped into pre-summation groups, whose size comes from a 2-bit select. Then the groups are counted up to a programmable summation count, and that completes one accumulation interval. A one-clock pulse marks the end of every frame. A second pulse marks the end of every accumulation interval, so downstream logic knows when per-frame status or accumulated results are ready.

The configuration byte is written through a simple write port. It is staged and only applied at the next accumulation boundary, so an interval in progress is never cut short or stretched.

Top module: `mux_accum_sequencer`

## Requirements
- R1: One frame spans exactly 13 enabled ticks. `cycleDone` is high on the 13th tick of every frame and on no other tick.
- R2: `chanSel` walks through the slots in the order 0 = phase A current, 1 = phase A voltage, 2 = phase B current, 3 = phase B voltage, 4 = phase C current, 5 = phase C voltage. Each code is held for two enabled ticks. It reads 7 during the idle tick.
- R3: `sampleStrobe` is high on the first tick of each of the six slots and low otherwise. That gives six strobes per frame.
- R4: Bits [7:6] of the configuration byte select the group size in frames: 0 → 42, 1 → 50, 2 → 84, 3 → 100.
- R5: Bits [5:0] of the configuration byte give the number of groups per interval. A value of 0 means 64.
- R6: `xferDone` is high once per accumulation interval, on the same clock as the `cycleDone` that closes frame number (group size × group count).
- R7: A configuration write during an interval does not change that interval's length. The most recent write applies from the next interval onward.
- R8: Reset returns the sequencer to the first tick of slot 0 with all counters cleared. The first interval after reset uses the `RESET_CFG` parameter as its configuration.
- R9: Without `tickEn` nothing advances. `cycleDone`, `sampleStrobe` and `xferDone` are only ever high together with `tickEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-clock enable per 32768 Hz tick period |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrData | input | 8 | Configuration byte: group select [7:6], group count [5:0] |
| chanSel | output | 3 | Current slot channel code, 7 during idle tick |
| sampleStrobe | output | 1 | Start-of-slot sample request |
| cycleDone | output | 1 | End-of-frame pulse |
| xferDone | output | 1 | End-of-accumulation pulse |

## Verification
The first pattern holds the tick enable high continuously. It runs a short interval taken from the reset configuration, then a 50×2 interval, then the 42×64 case that comes from a zero count. This separates the four group sizes and the zero-means-64 rule through exact interval lengths. The second pattern drops the enable at random for about half the clocks, which separates true tick counting from clock counting. Configuration writes are also scattered inside intervals; they may only change the length of the following interval. A reset in the middle of an interval shows that every counter restarts and that the reset configuration returns.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;

  localparam int CHAN_W = 3;
  localparam int CNT_W  = 7;
  localparam logic [CHAN_W-1:0] CHAN_IDLE = '1;

  typedef struct packed {
    logic slotStart;
    logic frameEnd;
  } seqStrobe_t;

  function automatic logic [CNT_W-1:0] groupFrames(input logic [1:0] sel);
    case (sel)
      2'd0:    groupFrames = CNT_W'(42);
      2'd1:    groupFrames = CNT_W'(50);
      2'd2:    groupFrames = CNT_W'(84);
      default: groupFrames = CNT_W'(100);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] groupCount(input logic [5:0] field);
    groupCount = (field == 6'd0) ? CNT_W'(64) : {1'b0, field};
  endfunction

endpackage

// File: rtl/seq_frame_ctrl.sv
module seq_frame_ctrl
  import mux_seq_pkg::*;
#(
  parameter int TICKS_PER_SLOT = 2,
  parameter int NUM_SLOTS      = 6,
  parameter int IDLE_TICKS     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  output seqStrobe_t        strobes,
  output logic [CHAN_W-1:0] chanSel
);

  localparam int PW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
  localparam int IW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;
  localparam int SW = $clog2(NUM_SLOTS + 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(TICKS_PER_SLOT - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_TICKS - 1);
  localparam logic [SW-1:0] SLOT_IDLE = SW'(NUM_SLOTS);

  logic [PW-1:0] slotPhase;
  logic [IW-1:0] idleCnt;
  logic [SW-1:0] slotIdx;
  logic          inIdle;

  assign inIdle = (slotIdx == SLOT_IDLE);

  always_comb begin
    strobes.slotStart = tickEn && !inIdle && (slotPhase == '0);
    strobes.frameEnd  = tickEn && inIdle && (idleCnt == IDLE_LAST);
    chanSel           = inIdle ? CHAN_IDLE : CHAN_W'(slotIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotPhase <= '0;
      idleCnt   <= '0;
      slotIdx   <= '0;
    end else if (tickEn) begin
      if (!inIdle) begin
        if (slotPhase == PH_LAST) begin
          slotPhase <= '0;
          slotIdx   <= slotIdx + 1'b1;
        end else begin
          slotPhase <= slotPhase + 1'b1;
        end
        idleCnt <= '0;
      end else if (idleCnt == IDLE_LAST) begin
        idleCnt <= '0;
        slotIdx <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/seq_accum_datapath.sv
module seq_accum_datapath
  import mux_seq_pkg::*;
#(
  parameter int         CFG_W     = 8,
  parameter logic [7:0] RESET_CFG = 8'h32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobes,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             intervalEnd
);

  logic [CFG_W-1:0] pendCfg;
  logic [CFG_W-1:0] activeCfg;
  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] sumCnt;
  logic [CNT_W-1:0] preLast;
  logic [CNT_W-1:0] sumLast;
  logic             groupEnd;

  assign preLast     = groupFrames(activeCfg[7:6]) - 1'b1;
  assign sumLast     = groupCount(activeCfg[5:0]) - 1'b1;
  assign groupEnd    = strobes.frameEnd && (preCnt == preLast);
  assign intervalEnd = groupEnd && (sumCnt == sumLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCfg <= RESET_CFG;
    end else if (cfgWrEn) begin
      pendCfg <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeCfg <= RESET_CFG;
      preCnt    <= '0;
      sumCnt    <= '0;
    end else if (strobes.frameEnd) begin
      if (groupEnd) begin
        preCnt <= '0;
        if (intervalEnd) begin
          sumCnt    <= '0;
          activeCfg <= pendCfg;
        end else begin
          sumCnt <= sumCnt + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mux_accum_sequencer.sv
module mux_accum_sequencer
  import mux_seq_pkg::*;
#(
  parameter int         TICKS_PER_SLOT = 2,
  parameter int         NUM_SLOTS      = 6,
  parameter int         IDLE_TICKS     = 1,
  parameter logic [7:0] RESET_CFG      = 8'h32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [2:0] chanSel,
  output logic       sampleStrobe,
  output logic       cycleDone,
  output logic       xferDone
);

  seqStrobe_t strobes;

  seq_frame_ctrl #(
    .TICKS_PER_SLOT(TICKS_PER_SLOT),
    .NUM_SLOTS     (NUM_SLOTS),
    .IDLE_TICKS    (IDLE_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tickEn (tickEn),
    .strobes(strobes),
    .chanSel(chanSel)
  );

  seq_accum_datapath #(
    .CFG_W    (8),
    .RESET_CFG(RESET_CFG)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .intervalEnd(xferDone)
  );

  assign sampleStrobe = strobes.slotStart;
  assign cycleDone    = strobes.frameEnd;

endmodule

// File: rtl/mux_accum_sequencer_chk.sv
module mux_accum_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tickEn,
  input logic [2:0] chanSel,
  input logic       sampleStrobe,
  input logic       cycleDone,
  input logic       xferDone
);

  p_pulse_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleDone || sampleStrobe || xferDone) |-> tickEn);

  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(chanSel));

  p_xfer_on_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xferDone |-> cycleDone);

  p_frame_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |=> (chanSel == 3'd0) && !cycleDone);

  p_slot_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |=> (chanSel == $past(chanSel)) && !sampleStrobe);

  p_chan_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chanSel <= 3'd5) || (chanSel == 3'd7));

  p_strobe_not_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |-> (chanSel != 3'd7) && !cycleDone);

endmodule

bind mux_accum_sequencer mux_accum_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tickEn      (tickEn),
  .chanSel     (chanSel),
  .sampleStrobe(sampleStrobe),
  .cycleDone   (cycleDone),
  .xferDone    (xferDone)
);

// File: tb/mux_accum_sequencer_test.sv
module mux_accum_sequencer_test;

  localparam logic [7:0] RST_CFG = 8'h01;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [2:0] chanSel;
  logic       sampleStrobe, cycleDone, xferDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit timedOut = 1'b0;

  int mTick, mPre, mSum, framesSince, xferSeen;
  logic [7:0] mActive, mPend;

  always #10 clk = ~clk;

  mux_accum_sequencer #(.RESET_CFG(RST_CFG)) uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .chanSel(chanSel), .sampleStrobe(sampleStrobe),
    .cycleDone(cycleDone), .xferDone(xferDone)
  );

  function automatic int expGroup(input logic [1:0] s);
    if (s == 2'd0) return 42;
    if (s == 2'd1) return 50;
    if (s == 2'd2) return 84;
    return 100;
  endfunction

  function automatic int expCount(input logic [5:0] f);
    return (f == 6'd0) ? 64 : int'(f);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic modelReset();
    mTick = 0; mPre = 0; mSum = 0; framesSince = 0;
    mActive = RST_CFG; mPend = RST_CFG;
  endtask

  task automatic step(input bit en, input bit wr, input logic [7:0] data);
    int pl, sl;
    bit expDone, expXfer;
    @(negedge clk);
    tickEn = en; cfgWrEn = wr; cfgWrData = data;
    #1;
    cycles++;
    pl = expGroup(mActive[7:6]);
    sl = expCount(mActive[5:0]);
    expDone = en && (mTick == 12);
    expXfer = expDone && (mPre == pl - 1) && (mSum == sl - 1);
    check("R2 chanSel", int'(chanSel), (mTick < 12) ? mTick / 2 : 7);
    check("R3/R9 sampleStrobe", int'(sampleStrobe), int'(en && mTick < 12 && mTick % 2 == 0));
    check("R1/R9 cycleDone", int'(cycleDone), int'(expDone));
    check("R6 xferDone", int'(xferDone), int'(expXfer));
    if (cycleDone) framesSince++;
    if (xferDone) begin
      xferSeen++;
      check("R4/R5/R7 interval frames", framesSince, pl * sl);
      framesSince = 0;
    end
    if (en) begin
      if (mTick == 12) begin
        mTick = 0;
        if (mPre == pl - 1) begin
          mPre = 0;
          if (mSum == sl - 1) begin
            mSum = 0;
            mActive = mPend;
          end else mSum++;
        end else mPre++;
      end else mTick++;
    end
    if (wr) mPend = data;
    if (cycles > 190000) timedOut = 1'b1;
  endtask

  task automatic runIntervals(input int n, input bit randEn, input bit randWr);
    int target;
    target = xferSeen + n;
    while (xferSeen < target && !timedOut) begin
      bit en, wr;
      logic [7:0] d;
      en = randEn ? ($urandom % 2 == 0) : 1'b1;
      wr = randWr && ($urandom % 400 == 0);
      d = {2'($urandom), 6'(1 + $urandom % 3)};
      step(en, wr, d);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    xferSeen = 0;
    modelReset();
    repeat (3) @(negedge clk);
    // R8: outputs at reset state
    check("R8 reset chanSel", int'(chanSel), 0);
    check("R8 reset cycleDone", int'(cycleDone), 0);
    check("R8 reset xferDone", int'(xferDone), 0);
    rst_n = 1'b1;
    // R8 first interval from reset cfg (42x1); R7 write 50x2 applies next
    step(1'b1, 1'b1, 8'h42);
    runIntervals(1, 1'b0, 1'b0);
    // second interval 100 frames; R5 zero-count written mid interval
    repeat (50) step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'h00);
    runIntervals(1, 1'b0, 1'b0);
    // 42x64 interval; queue 100x3
    repeat (20) step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'hC3);
    runIntervals(1, 1'b0, 1'b0);
    // R9 random enable, R7 random mid-interval writes
    step(1'b1, 1'b1, 8'h81);
    runIntervals(4, 1'b1, 1'b1);
    // R8 mid-interval reset
    repeat (300) step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'hC2);
    @(negedge clk);
    tickEn = 1'b0; cfgWrEn = 1'b0;
    rst_n = 1'b0;
    #1;
    modelReset();
    check("R8 mid reset chanSel", int'(chanSel), 0);
    check("R8 mid reset cycleDone", int'(cycleDone), 0);
    @(negedge clk);
    rst_n = 1'b1;
    runIntervals(2, 1'b1, 1'b0);
    if (timedOut) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule